// File: doc/BRIEF.md
# Canonical Huffman Codeword Assigner

This block turns a table of per-symbol code lengths into canonical prefix codes. Before a run, the host loads the code length of every symbol and a histogram that gives the number of symbols using each length. Loading goes through one write port that selects one of the two tables. A start pulse first builds the starting code for each length, one length per clock. The block then steps through the symbols from index 0 upward, one per clock. Each symbol with a nonzero length takes the next free code of its length.

Every result leaves as one packed word with the code length in the low bits. Above the length sits the code, mirrored so that its first bit is at the lowest position of the code field. A decoder or bit packer that works least-significant-bit first can then shift the bits out directly. Results stream out in symbol order with a valid flag. A one-cycle done pulse closes the run.

Top module: `huff_canon_top`

## Requirements
- R1: After a synchronous reset, busy, out_valid and done are low and both tables are zero. A run started with no writes since reset emits an all-zero word for every symbol.
- R2: The starting code for length 1 is 0. For each length L from 2 to MAX_LEN, the starting code is (start(L-1) + hist(L-1)) shifted left by one bit, kept to MAX_LEN bits.
- R3: Symbols are visited in ascending index order. A symbol of length L receives the current next code of L, and that counter then increments by one, so codes of equal length are consecutive in index order.
- R4: A symbol whose length is 0 yields an all-zero output word and consumes no code.
- R5: For a length-L code, the code is mirrored across the MAX_LEN-bit field and then shifted right by MAX_LEN-L. Code-field bit j therefore holds the code's bit L-1-j, with the first (most significant) code bit at bit 0.
- R6: out_word bits [4:0] hold the code length and bits [20:5] hold the mirrored code (default parameters).
- R7: The first out_valid appears MAX_LEN+1 clocks after the clock edge that samples start. The 256 results then follow in unbroken consecutive cycles, out_symbol counting 0 to 255.
- R8: done is high for exactly one cycle, in the cycle right after the result for symbol 255.
- R9: While busy is high, table writes and start are ignored. A later run without new writes gives the same results.
- R10: A table write with cfg_sel=0 stores cfg_data[4:0] as the length of symbol cfg_addr. A write with cfg_sel=1 stores cfg_data as the histogram count of length cfg_addr (1..MAX_LEN).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 1 | Table select: 0 length table, 1 histogram |
| cfg_addr | input | 8 | Symbol index or code length |
| cfg_data | input | 9 | Length value or histogram count |
| start | input | 1 | Begin a run (sampled while idle) |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Result valid this cycle |
| out_symbol | output | 8 | Symbol index of the result |
| out_word | output | 21 | Mirrored code above a 5-bit length |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach from the ports is a table write, or a second start, that arrives in the middle of a run. The bench issues both while symbols are streaming, with values that differ from the loaded tables. It then compares the run against results computed from the original tables. A second run follows without any reload, so any write that slipped into storage shows up as changed words. Further runs cover the longest code length, lengths that alternate between symbols, zero-length gaps and the unloaded state right after reset.

// File: rtl/huff_pkg.sv
package huff_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIN  = 2'd3
    } huff_state_e;

    typedef enum logic {
        TGT_LEN  = 1'b0,
        TGT_HIST = 1'b1
    } cfg_tgt_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/huff_len_table.sv
module huff_len_table #(
    parameter int NUM_SYMS = 256,
    parameter int SYM_W    = 8,
    parameter int LEN_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SYM_W-1:0] waddr,
    input  logic [LEN_W-1:0] wdata,
    input  logic [SYM_W-1:0] raddr,
    output logic [LEN_W-1:0] rdata
);

    logic [LEN_W-1:0] len_mem [NUM_SYMS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SYMS; i++) len_mem[i] <= '0;
        end else if (we && int'(waddr) < NUM_SYMS) begin
            len_mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < NUM_SYMS) rdata = len_mem[raddr];
    end

endmodule

// File: rtl/huff_next_code.sv
module huff_next_code #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    parameter int CNT_W   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hist_we,
    input  logic [LEN_W-1:0]   hist_addr,
    input  logic [CNT_W-1:0]   hist_data,
    input  logic               init_en,
    input  logic [LEN_W-1:0]   init_idx,
    input  logic               use_en,
    input  logic [LEN_W-1:0]   use_len,
    output logic [MAX_LEN-1:0] use_code
);

    logic [CNT_W-1:0]   hist_q [MAX_LEN+1];
    logic [MAX_LEN-1:0] ctr_q  [MAX_LEN+1];

    logic [LEN_W-1:0]   prev_idx;
    logic [MAX_LEN-1:0] prev_sum;
    logic [MAX_LEN-1:0] seed_val;
    logic               use_ok;

    always_comb begin
        prev_idx = init_idx - LEN_W'(1);
        prev_sum = '0;
        if (int'(prev_idx) <= MAX_LEN)
            prev_sum = ctr_q[prev_idx] + MAX_LEN'(hist_q[prev_idx]);
        seed_val = (init_idx == LEN_W'(1)) ? '0 : {prev_sum[MAX_LEN-2:0], 1'b0};
        use_ok   = (use_len != '0) && (int'(use_len) <= MAX_LEN);
        use_code = use_ok ? ctr_q[use_len] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= MAX_LEN; i++) begin
                hist_q[i] <= '0;
                ctr_q[i]  <= '0;
            end
        end else begin
            if (hist_we && int'(hist_addr) <= MAX_LEN)
                hist_q[hist_addr] <= hist_data;
            if (init_en && int'(init_idx) <= MAX_LEN)
                ctr_q[init_idx] <= seed_val;
            else if (use_en && use_ok)
                ctr_q[use_len] <= ctr_q[use_len] + MAX_LEN'(1);
        end
    end

    AST_INIT_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (init_en && init_idx != LEN_W'(1)) |-> ($past(init_en) && init_idx == $past(init_idx) + LEN_W'(1))); // R2
    AST_NO_INIT_DURING_USE: assert property (@(posedge clk) disable iff (rst)
        !(init_en && use_en)); // R3

endmodule

// File: rtl/huff_pack.sv
module huff_pack #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    localparam int WORD_W = MAX_LEN + LEN_W
) (
    input  logic [MAX_LEN-1:0] code,
    input  logic [LEN_W-1:0]   len,
    output logic [WORD_W-1:0]  word
);

    logic [MAX_LEN-1:0] mirrored;
    logic [MAX_LEN-1:0] aligned;

    generate
        for (genvar b = 0; b < MAX_LEN; b++) begin : g_mirror
            assign mirrored[b] = code[MAX_LEN-1-b];
        end
    endgenerate

    always_comb begin
        aligned = '0;
        word    = '0;
        if (len != '0 && int'(len) <= MAX_LEN) begin
            aligned = mirrored >> (MAX_LEN - int'(len));
            word    = {aligned, len};
        end
    end

endmodule

// File: rtl/huff_canon_top.sv
module huff_canon_top
    import huff_pkg::*;
#(
    parameter int NUM_SYMS = 256,
    parameter int MAX_LEN  = 16,
    localparam int SYM_W   = $clog2(NUM_SYMS),
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int CNT_W   = $clog2(NUM_SYMS + 1),
    localparam int CFG_W   = (LEN_W > CNT_W) ? LEN_W : CNT_W,
    localparam int ADDR_W  = (SYM_W > LEN_W) ? SYM_W : LEN_W,
    localparam int WORD_W  = MAX_LEN + LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              start,
    output logic              busy,
    output logic              out_valid,
    output logic [SYM_W-1:0]  out_symbol,
    output logic [WORD_W-1:0] out_word,
    output logic              done
);

    huff_state_e        state_q;
    logic [LEN_W-1:0]   len_idx_q;
    logic [SYM_W-1:0]   sym_q;

    logic               cfg_ok;
    logic               len_we;
    logic               hist_we;
    logic [LEN_W-1:0]   sym_len;
    logic [MAX_LEN-1:0] sym_code;
    logic [WORD_W-1:0]  sym_word;

    assign busy    = (state_q != ST_IDLE);
    assign cfg_ok  = cfg_we && (state_q == ST_IDLE);
    assign len_we  = cfg_ok && (cfg_tgt_e'(cfg_sel) == TGT_LEN) && (int'(cfg_addr) < NUM_SYMS);
    assign hist_we = cfg_ok && (cfg_tgt_e'(cfg_sel) == TGT_HIST) && (int'(cfg_addr) <= MAX_LEN);

    huff_len_table #(.NUM_SYMS(NUM_SYMS), .SYM_W(SYM_W), .LEN_W(LEN_W)) len_tab_i (
        .clk   (clk),
        .rst   (rst),
        .we    (len_we),
        .waddr (cfg_addr[SYM_W-1:0]),
        .wdata (cfg_data[LEN_W-1:0]),
        .raddr (sym_q),
        .rdata (sym_len)
    );

    huff_next_code #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)) next_code_i (
        .clk       (clk),
        .rst       (rst),
        .hist_we   (hist_we),
        .hist_addr (cfg_addr[LEN_W-1:0]),
        .hist_data (cfg_data[CNT_W-1:0]),
        .init_en   (state_q == ST_INIT),
        .init_idx  (len_idx_q),
        .use_en    (state_q == ST_RUN),
        .use_len   (sym_len),
        .use_code  (sym_code)
    );

    huff_pack #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) pack_i (
        .code (sym_code),
        .len  (sym_len),
        .word (sym_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            len_idx_q  <= '0;
            sym_q      <= '0;
            out_valid  <= 1'b0;
            out_symbol <= '0;
            out_word   <= '0;
            done       <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q   <= ST_INIT;
                        len_idx_q <= LEN_W'(1);
                    end
                end
                ST_INIT: begin
                    if (len_idx_q == LEN_W'(MAX_LEN)) begin
                        state_q <= ST_RUN;
                        sym_q   <= '0;
                    end else begin
                        len_idx_q <= len_idx_q + LEN_W'(1);
                    end
                end
                ST_RUN: begin
                    out_valid  <= 1'b1;
                    out_symbol <= sym_q;
                    out_word   <= sym_word;
                    if (sym_q == SYM_W'(NUM_SYMS - 1)) state_q <= ST_FIN;
                    else                               sym_q   <= sym_q + SYM_W'(1);
                end
                default: begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_symbol == SYM_W'(NUM_SYMS - 1)) |=> done); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_SYM_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_symbol != '0) |-> ($past(out_valid) && out_symbol == $past(out_symbol) + SYM_W'(1))); // R7
    AST_ZERO_LEN_WORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[LEN_W-1:0] == '0) |-> (out_word == '0)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !out_valid); // R9

endmodule

// File: tb/huff_canon_top_tb.sv
module huff_canon_top_tb_top;

    localparam int NUM_SYMS = 256;
    localparam int MAX_LEN  = 16;
    localparam int SYM_W    = 8;
    localparam int LEN_W    = 5;
    localparam int CFG_W    = 9;
    localparam int ADDR_W   = 8;
    localparam int WORD_W   = 21;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [CFG_W-1:0]  cfg_data = '0;
    logic              start = 1'b0;
    logic              busy;
    logic              out_valid;
    logic [SYM_W-1:0]  out_symbol;
    logic [WORD_W-1:0] out_word;
    logic              done;

    always #4 clk = ~clk;

    huff_canon_top #(.NUM_SYMS(NUM_SYMS), .MAX_LEN(MAX_LEN)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .start(start),
        .busy(busy), .out_valid(out_valid), .out_symbol(out_symbol),
        .out_word(out_word), .done(done)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc = 0;
    int lens [NUM_SYMS];
    int exp_word [NUM_SYMS];
    int n_out, n_done, first_cyc, last_cyc, start_cyc;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (n_out == 0) first_cyc = cyc;
                chk(int'(out_symbol) == n_out, "R7", "symbol order", int'(out_symbol), n_out);
                if (lens[out_symbol] == 0)
                    chk(int'(out_word) == exp_word[out_symbol], "R4", "zero-length word", int'(out_word), exp_word[out_symbol]);
                else
                    chk(int'(out_word) == exp_word[out_symbol], "R2 R3 R5 R6", "code word", int'(out_word), exp_word[out_symbol]);
                n_out++;
                last_cyc = cyc;
            end
            if (done) begin
                n_done++;
                chk(cyc == last_cyc + 1 && n_out == NUM_SYMS, "R8", "done timing", cyc - last_cyc, 1);
            end
        end
    end

    task automatic wr(input bit sel, input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = ADDR_W'(addr); cfg_data = CFG_W'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic compute_expected();
        int hist [MAX_LEN+1];
        int nxt  [MAX_LEN+1];
        for (int l = 0; l <= MAX_LEN; l++) hist[l] = 0;
        for (int s = 0; s < NUM_SYMS; s++) hist[lens[s]]++;
        nxt[1] = 0;
        for (int l = 2; l <= MAX_LEN; l++) nxt[l] = ((nxt[l-1] + hist[l-1]) * 2) % 65536;
        for (int s = 0; s < NUM_SYMS; s++) begin
            int l = lens[s];
            int rev = 0;
            if (l == 0) exp_word[s] = 0;
            else begin
                for (int j = 0; j < l; j++)
                    if ((nxt[l] >> (l - 1 - j)) & 1) rev |= (1 << j);
                exp_word[s] = rev * 32 + l;
                nxt[l] = (nxt[l] + 1) % 65536;
            end
        end
    endtask

    task automatic load_tables();
        int hist [MAX_LEN+1];
        for (int l = 0; l <= MAX_LEN; l++) hist[l] = 0;
        for (int s = 0; s < NUM_SYMS; s++) begin
            hist[lens[s]]++;
            wr(1'b0, s, lens[s]);                 // R10 length table
        end
        for (int l = 1; l <= MAX_LEN; l++) wr(1'b1, l, hist[l]);  // R10 histogram
    endtask

    task automatic run(input string name, input bit disturb);
        int guard = 0;
        n_out = 0; n_done = 0; first_cyc = 0; last_cyc = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        start_cyc = cyc;
        chk(busy == 1'b1, "R7", {name, " busy after start"}, int'(busy), 1);
        if (disturb) begin
            repeat (40) @(negedge clk);
            // R9: writes and start while busy must be ignored
            cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = 8'd200; cfg_data = 9'd3;
            start = 1'b1;
            @(negedge clk);
            cfg_sel = 1'b1; cfg_addr = 8'd9; cfg_data = 9'd77;
            @(negedge clk);
            cfg_sel = 1'b0; cfg_addr = 8'd255; cfg_data = 9'd1;
            @(negedge clk);
            cfg_we = 1'b0; start = 1'b0;
        end
        while (n_done == 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        chk(first_cyc - start_cyc == MAX_LEN + 1, "R7", {name, " first output latency"}, first_cyc - start_cyc, MAX_LEN + 1);
        chk(n_out == NUM_SYMS, "R7", {name, " result count"}, n_out, NUM_SYMS);
        chk(n_done == 1, "R8", {name, " done pulses"}, n_done, 1);
        chk(busy == 1'b0, "R9", {name, " idle after run"}, int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R1", "reset outputs", {busy, out_valid, done}, 0);

        // R1: unloaded tables give all-zero words
        for (int s = 0; s < NUM_SYMS; s++) lens[s] = 0;
        compute_expected();
        run("unloaded", 1'b0);

        // flat length 8: code equals index, mirrored
        for (int s = 0; s < NUM_SYMS; s++) lens[s] = 8;
        load_tables(); compute_expected();
        run("flat8", 1'b0);

        // lengths 1..16 with two of length 16, remainder unused
        for (int s = 0; s < NUM_SYMS; s++) lens[s] = (s < 16) ? s + 1 : ((s == 16) ? 16 : 0);
        load_tables(); compute_expected();
        run("chain", 1'b0);

        // interleaved lengths 9 and 10 with zero-length gaps
        for (int s = 0; s < NUM_SYMS; s++) lens[s] = (s % 3 == 0) ? 0 : ((s % 3 == 1) ? 9 : 10);
        load_tables(); compute_expected();
        run("mixed", 1'b1);
        run("mixed rerun", 1'b0);   // R9 tables untouched by busy writes

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule